// File: doc/BRIEF.md
# DMA Channel Address/Count Sequencer

This block is the transfer engine of a single channel in a legacy-style DMA controller. Software programs a 16-bit start address, a 16-bit count and an 8-bit page. Each accepted transfer strobe advances the current address by one and lowers the current count by one. The block forms the physical bus address from the page and the current address, in byte mode or in word mode.

The programmed count is one less than the number of transfers. The transfer that takes the count from zero to all-ones raises terminal count. If autoinit is set, the channel then reloads its start address and count and keeps running. If not, it goes idle and ignores strobes until it is programmed again. The low 16-bit address wraps inside its region and never carries into the page. The residue output gives the number of units still to move.

Top module: `dma_seq`

## Requirements
- R1: After reset, active_o is 0, phys_addr_o is 0 and residue_o is 1 (current address, count and page are all 0).
- R2: A cycle with prog_i high loads base_addr_i and base_cnt_i into both the stored base registers and the current registers, loads page_i, and sets active_o to 1 from the next cycle.
- R3: A transfer is accepted when xfer_i is high, active_o is 1 and prog_i is low. On each accepted transfer the current address steps up by one (mod 2^16) and the current count steps down by one (mod 2^16).
- R4: tc_o is high, in the same cycle, exactly for an accepted transfer made while the current count is 0x0000. A programmed count N gives tc_o on the (N+1)-th transfer: 0x0000 gives 1 transfer and 0xFFFF gives 65536.
- R5: With word_mode_i low, phys_addr_o = {page[7:0], addr[15:0]} (24 bits).
- R6: With word_mode_i high, phys_addr_o = {page[7:1], addr[15:0], 1'b0}. Page bit 0 has no effect and bit 0 of the output is always 0.
- R7: The address wraps from 0xFFFF to 0x0000 and the page stays the same. The page changes only through prog_i.
- R8: With autoinit_i low, the terminal-count transfer clears active_o. Later xfer_i strobes leave phys_addr_o, residue_o and tc_o unchanged until prog_i.
- R9: With autoinit_i high, the terminal-count transfer reloads the current address and count from the base registers, and active_o stays 1.
- R10: residue_o equals current count + 1 mod 2^16, so it reads 0 after a non-autoinit run completes.
- R11: When prog_i and xfer_i are high in the same cycle, the load takes effect, no step is made and tc_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_i | input | 1 | Load base/current address, count and page |
| base_addr_i | input | 16 | Start address in transfer units |
| base_cnt_i | input | 16 | Transfer count minus one |
| page_i | input | 8 | Page value |
| word_mode_i | input | 1 | 1: 16-bit word transfers; 0: byte transfers |
| autoinit_i | input | 1 | Reload from base on terminal count |
| xfer_i | input | 1 | Transfer acknowledge strobe |
| phys_addr_o | output | 24 | Physical bus address |
| tc_o | output | 1 | Terminal count, high during the last transfer |
| residue_o | output | 16 | Current count + 1 |
| active_o | output | 1 | Channel accepts transfers |

## Verification
The assertions check every cycle that the address steps by one per accepted transfer, that the page holds steady without a load, that a word-mode address is even, and that terminal count leads to an idle channel with zero residue or to a reload from base. Only the bench scenarios show the exact transfer count before terminal count, from a single transfer up to the full 65536. They also show the byte and word address layouts across page and address patterns, the wrap at 0xFFFF, and that strobes are ignored once idle. The priority of a load over a simultaneous strobe is also shown there.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned PHYS_W = PAGE_W + ADDR_W;
endpackage

// File: rtl/dma_seq_ctr.sv
module dma_seq_ctr #(
  parameter int unsigned W    = 16,
  parameter bit          DOWN = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, stepped;

  generate
    if (DOWN) begin : g_down
      assign stepped = q_q - W'(1);
    end else begin : g_up
      assign stepped = q_q + W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (load_i)   q_q <= load_val_i;
    else if (reload_i) q_q <= reload_val_i;
    else if (step_i)   q_q <= stepped;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_seq_phys.sv
module dma_seq_phys #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned PHYS_W = PAGE_W + ADDR_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_mode_i,
  output logic [PHYS_W-1:0] phys_o
);
  // word mode: page lsb dropped, unit address shifted up one bit
  always_comb begin
    if (word_mode_i) phys_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
    else             phys_o = {page_i, addr_i};
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              word_mode_i,
  input  logic              autoinit_i,
  input  logic              xfer_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              tc_o,
  output logic [CNT_W-1:0]  residue_o,
  output logic              active_o
);
  logic [ADDR_W-1:0] base_addr_q, cur_addr;
  logic [CNT_W-1:0]  base_cnt_q, cur_cnt;
  logic [PAGE_W-1:0] page_q;
  logic              active_q, accept, last, reload;

  assign accept = xfer_i & active_q & ~prog_i;
  assign last   = accept & (cur_cnt == '0);
  assign reload = last & autoinit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      active_q    <= 1'b0;
    end else if (prog_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      page_q      <= page_i;
      active_q    <= 1'b1;
    end else if (last && !autoinit_i) begin
      active_q    <= 1'b0;
    end
  end

  dma_seq_ctr #(.W(ADDR_W), .DOWN(1'b0)) u_addr (
    .clk_i, .rst_ni,
    .load_i(prog_i), .load_val_i(base_addr_i),
    .step_i(accept),
    .reload_i(reload), .reload_val_i(base_addr_q),
    .q_o(cur_addr)
  );

  dma_seq_ctr #(.W(CNT_W), .DOWN(1'b1)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(prog_i), .load_val_i(base_cnt_i),
    .step_i(accept),
    .reload_i(reload), .reload_val_i(base_cnt_q),
    .q_o(cur_cnt)
  );

  dma_seq_phys #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_phys (
    .page_i(page_q), .addr_i(cur_addr), .word_mode_i,
    .phys_o(phys_addr_o)
  );

  assign tc_o      = last;
  assign residue_o = cur_cnt + CNT_W'(1);
  assign active_o  = active_q;

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !reload) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

  // R7
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |=> $stable(page_q));

  // R6
  word_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_mode_i |-> phys_addr_o[0] == 1'b0);

  // R8
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !autoinit_i) |=> (!active_o && residue_o == '0));

  // R9
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && autoinit_i) |=> (active_o && cur_addr == base_addr_q && cur_cnt == base_cnt_q));

  // R11
  prog_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |-> !tc_o);
endmodule

// File: tb/dma_seq_tb.sv
module dma_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_i = 1'b0;
  logic [15:0] base_addr_i = '0;
  logic [15:0] base_cnt_i = '0;
  logic [7:0]  page_i = '0;
  logic        word_mode_i = 1'b0;
  logic        autoinit_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [23:0] phys_addr_o;
  logic        tc_o;
  logic [15:0] residue_o;
  logic        active_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected model
  logic [15:0] e_addr, e_cnt, e_baddr, e_bcnt;
  logic [7:0]  e_page;
  logic        e_act;

  always #4 clk_i = ~clk_i;

  dma_seq u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] e_phys();
    return word_mode_i ? {e_page[7:1], e_addr, 1'b0} : {e_page, e_addr};
  endfunction

  task automatic prog(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p);
    @(negedge clk_i);
    prog_i = 1'b1; base_addr_i = a; base_cnt_i = c; page_i = p;
    @(posedge clk_i); #1 prog_i = 1'b0;
    e_addr = a; e_cnt = c; e_baddr = a; e_bcnt = c; e_page = p; e_act = 1'b1;
    chk("R2 active", {31'd0, active_o}, 32'd1);
    chk("R2 residue", {16'd0, residue_o}, {16'd0, c + 16'd1});
  endtask

  // one strobe; returns observed tc
  task automatic xfer(output logic tc);
    logic e_tc;
    @(negedge clk_i);
    xfer_i = 1'b1;
    #1 tc = tc_o;
    e_tc = e_act && (e_cnt == 16'h0000);
    chk("R4 tc", {31'd0, tc}, {31'd0, e_tc});
    @(posedge clk_i); #1 xfer_i = 1'b0;
    if (e_act) begin
      if (e_tc && autoinit_i) begin
        e_addr = e_baddr; e_cnt = e_bcnt;
      end else begin
        e_addr = e_addr + 16'd1; e_cnt = e_cnt - 16'd1;
        if (e_tc) e_act = 1'b0;
      end
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " phys"}, {8'd0, phys_addr_o}, {8'd0, e_phys()});
    chk({req, " residue"}, {16'd0, residue_o}, {16'd0, e_cnt + 16'd1});
    chk({req, " active"}, {31'd0, active_o}, {31'd0, e_act});
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic tc;
    int ntc;
    e_addr = '0; e_cnt = '0; e_page = '0; e_act = 1'b0; e_baddr = '0; e_bcnt = '0;
    #20 rst_ni = 1'b1;
    #3;
    // R1
    chk("R1 active", {31'd0, active_o}, 32'd0);
    chk("R1 phys", {8'd0, phys_addr_o}, 32'd0);
    chk("R1 residue", {16'd0, residue_o}, 32'd1);

    // R3 R5 R7: byte mode, wrap across 0xFFFF, count 3 -> 4 transfers
    prog(16'hFFFE, 16'd3, 8'h5A);
    chk_state("R5");
    for (int i = 0; i < 4; i++) begin
      xfer(tc);
      chk_state("R3 R7");
    end
    chk("R7 page kept", {24'd0, phys_addr_o[23:16]}, 32'h5A);
    chk("R10 zero residue", {16'd0, residue_o}, 32'd0);
    // R8: strobes ignored after completion
    for (int i = 0; i < 3; i++) begin
      xfer(tc);
      chk("R8 no tc", {31'd0, tc}, 32'd0);
      chk_state("R8");
    end

    // R6: word mode sweep over page bit0 and address patterns
    word_mode_i = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        prog(16'h1234 ^ (16'h4321 * k[15:0]), 16'd1, 8'hA0 | p[7:0]);
        chk_state("R6");
        xfer(tc);
        chk_state("R6 step");
      end
    end
    // R6: word-mode wrap stays in 128K region, page bit0 ignored
    prog(16'hFFFF, 16'd0, 8'h33);
    xfer(tc);
    chk("R6 wrap", {8'd0, phys_addr_o}, 32'h320000);
    word_mode_i = 1'b0;

    // R4: count 0 gives exactly one transfer
    prog(16'h0100, 16'h0000, 8'h01);
    xfer(tc);
    chk("R4 single", {31'd0, tc}, 32'd1);
    chk_state("R4");

    // R9: autoinit reload
    autoinit_i = 1'b1;
    prog(16'h0040, 16'd2, 8'h07);
    for (int i = 0; i < 7; i++) begin
      xfer(tc);
      chk_state("R9");
    end
    chk("R9 active", {31'd0, active_o}, 32'd1);
    autoinit_i = 1'b0;

    // R11: prog with simultaneous xfer
    prog(16'h0010, 16'd0, 8'h02);
    @(negedge clk_i);
    prog_i = 1'b1; xfer_i = 1'b1; base_addr_i = 16'h0800; base_cnt_i = 16'd5; page_i = 8'h09;
    #1 chk("R11 tc", {31'd0, tc_o}, 32'd0);
    @(posedge clk_i); #1 prog_i = 1'b0; xfer_i = 1'b0;
    e_addr = 16'h0800; e_cnt = 16'd5; e_baddr = e_addr; e_bcnt = e_cnt; e_page = 8'h09; e_act = 1'b1;
    chk_state("R11");

    // R4: full 65536-transfer run, tc only on the last one
    prog(16'h0000, 16'hFFFF, 8'h11);
    ntc = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk_i);
      xfer_i = 1'b1;
      #1 if (tc_o) begin
        ntc++;
        if (i != 65535) begin
          checks++; errors++;
          $display("FAIL R4 early tc actual %0d expected 65535", i);
        end
      end
      @(posedge clk_i); #1 xfer_i = 1'b0;
    end
    chk("R4 full tc count", ntc, 32'd1);
    chk("R10 full residue", {16'd0, residue_o}, 32'd0);
    chk("R7 full addr", {8'd0, phys_addr_o}, 32'h110000);
    chk("R8 full idle", {31'd0, active_o}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule